// File: doc/BRIEF.md
# Sense-Reversing Barrier

A single-group hardware barrier for a fixed set of `P` participants. Each participant signals that it has reached the rendezvous by pulsing its bit of `arrive` for one cycle. It then waits for its bit of `go` to come back high. The unit counts distinct arrivals. When the final participant of an episode arrives, the count returns to zero and one shared sense bit flips, which releases every waiter at once.

Each participant keeps a private sense bit that flips on each of its accepted arrivals. Its `go` is high exactly while the shared sense matches that private bit. The release condition therefore alternates from one episode to the next, so nothing has to be cleared between episodes. A participant that is released can arrive again at once without holding back anyone still leaving the earlier episode.

A one-cycle `all_arrived` pulse marks each release. A one-cycle `dup_err` pulse reports an arrival from a participant that is already waiting in the current episode; that arrival is ignored.

Top module: `sense_barrier`

## Requirements
- R1: After reset, every bit of `go` is 1, and `all_arrived` and `dup_err` are 0. The arrival count, the shared sense and all private senses are 0.
- R2: `go[i]` is 1 exactly when the shared sense equals participant i's private sense. An accepted `arrive[i]` flips that private sense, so `go[i]` reads 0 from the next cycle until release.
- R3: A release happens on the clock edge where the accepted arrivals bring the count to P. At that edge the count returns to 0 and the shared sense flips. Every `go` bit is then 1, and `all_arrived` is 1 for exactly the following cycle.
- R4: Arrivals from several participants in the same cycle are all counted, and can complete an episode together, including all P in one cycle.
- R5: An `arrive[i]` while participant i is already waiting in the current episode is ignored. It does not change `go` or the count, and `dup_err` is 1 in the next cycle.
- R6: A participant that has been released may arrive in the very next cycle. That arrival counts toward the next episode and leaves every other participant's `go` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| arrive | input | P | One-cycle arrival pulse per participant |
| go | output | P | Per-participant release; high while not waiting |
| all_arrived | output | 1 | One-cycle pulse after each release |
| dup_err | output | 1 | One-cycle pulse after an ignored repeated arrival |

## Verification
The bench builds the unit with P = 4. This is large enough for a single cycle to mix fresh and repeated arrivals, for two participants to complete an episode together, and for all four to arrive in one cycle. It is small enough that every release position can be listed in a short vector table. The table runs several episodes back to back, so the flip of the shared sense is exercised in both directions, along with an immediate re-arrival after release. A reset in the middle of an episode is tested separately.

// File: rtl/sense_barrier.sv
module sense_barrier #(
  parameter int P = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [P-1:0] arrive,
  output logic [P-1:0] go,
  output logic         all_arrived,
  output logic         dup_err
);
  localparam int CW = $clog2(P + 1);

  logic [CW-1:0] cnt;
  logic          gsense;
  logic [P-1:0]  lsense;
  logic [P-1:0]  waiting;
  logic [P-1:0]  fresh;
  logic [CW-1:0] fresh_n;
  logic [CW:0]   sum;
  logic          last;

  assign fresh = arrive & ~waiting;
  assign sum   = {1'b0, cnt} + {1'b0, fresh_n};
  assign last  = (sum == (CW+1)'(P));

  always_comb begin
    fresh_n = '0;
    for (int i = 0; i < P; i++) fresh_n = fresh_n + CW'(fresh[i]);
  end

  genvar g;
  generate
    for (g = 0; g < P; g++) begin : g_part
      assign go[g] = (gsense == lsense[g]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt         <= '0;
      gsense      <= 1'b0;
      lsense      <= '0;
      waiting     <= '0;
      all_arrived <= 1'b0;
      dup_err     <= 1'b0;
    end else begin
      lsense      <= lsense ^ fresh;
      dup_err     <= |(arrive & waiting);
      all_arrived <= last;
      if (last) begin
        cnt     <= '0;
        gsense  <= ~gsense;
        waiting <= '0;
      end else begin
        cnt     <= sum[CW-1:0];
        waiting <= waiting | fresh;
      end
    end
  end

  a_r3_count_below_p: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(P));

  a_r3_release_flips_sense: assert property (@(posedge clk) disable iff (!rst_n)
    all_arrived |-> (gsense != $past(gsense)));

  a_r3_all_go_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    all_arrived |-> (go == {P{1'b1}}));

  a_r2_waiter_held: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting & go) == '0);

  a_r5_repeat_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (|(arrive & waiting)) |=> (((lsense ^ $past(lsense)) & $past(arrive & waiting)) == '0));

  a_r5_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (|(arrive & waiting)) |=> dup_err);
endmodule

// File: tb/sense_barrier_test.sv
module sense_barrier_test;
  localparam int P = 4;
  localparam int NV = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [P-1:0] arrive = '0;
  logic [P-1:0] go;
  logic all_arrived, dup_err;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sense_barrier #(.P(P)) uut (
    .clk(clk), .rst_n(rst_n), .arrive(arrive),
    .go(go), .all_arrived(all_arrived), .dup_err(dup_err)
  );

  // {arrive, expected go, expected all_arrived, expected dup_err}
  localparam logic [9:0] VEC [NV] = '{
    {4'b0001, 4'b1110, 1'b0, 1'b0},
    {4'b0010, 4'b1100, 1'b0, 1'b0},
    {4'b0001, 4'b1100, 1'b0, 1'b1},
    {4'b1100, 4'b1111, 1'b1, 1'b0},
    {4'b0001, 4'b1110, 1'b0, 1'b0},
    {4'b0000, 4'b1110, 1'b0, 1'b0},
    {4'b1110, 4'b1111, 1'b1, 1'b0},
    {4'b1111, 4'b1111, 1'b1, 1'b0},
    {4'b0000, 4'b1111, 1'b0, 1'b0},
    {4'b0011, 4'b1100, 1'b0, 1'b0},
    {4'b0111, 4'b1000, 1'b0, 1'b1},
    {4'b1000, 4'b1111, 1'b1, 1'b0}
  };

  task automatic chk(input string tag, input logic [P-1:0] act, input logic [P-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step(input logic [P-1:0] a);
    arrive = a;
    @(posedge clk); #1;
    arrive = '0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 go", go, 4'b1111);
    chk("R1 all_arrived", {3'b0, all_arrived}, 4'b0);
    chk("R1 dup_err", {3'b0, dup_err}, 4'b0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    for (int k = 0; k < NV; k++) begin
      step(VEC[k][9:6]);
      chk($sformatf("R2 go v%0d", k), go, VEC[k][5:2]);
      chk($sformatf("R3 all_arrived v%0d", k), {3'b0, all_arrived}, {3'b0, VEC[k][1]});
      chk($sformatf("R5 dup_err v%0d", k), {3'b0, dup_err}, {3'b0, VEC[k][0]});
    end

    // R4: all four at once completes an episode
    step(4'b1111);
    chk("R4 go", go, 4'b1111);
    chk("R4 all_arrived", {3'b0, all_arrived}, 4'b0001);

    // R6: immediate re-arrival after release leaves others released
    step(4'b0100);
    chk("R6 go", go, 4'b1011);
    step(4'b0000);
    chk("R6 all_arrived low", {3'b0, all_arrived}, 4'b0);
    step(4'b1011);
    chk("R6 next episode releases", {3'b0, all_arrived}, 4'b0001);

    // R1: reset in mid-episode
    step(4'b0011);
    chk("R1 pre-reset go", go, 4'b1100);
    rst_n = 1'b0;
    #1;
    chk("R1 go after reset", go, 4'b1111);
    @(posedge clk); #1;
    rst_n = 1'b1;
    step(4'b0001);
    chk("R1 count cleared", go, 4'b1110);
    step(4'b1110);
    chk("R1 release after reset", {3'b0, all_arrived}, 4'b0001);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule